// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block gathers hardware interrupt requests from a fixed set of on-chip sources and picks one to present to the CPU. Each source has a request flag that its own event sets, and an enable flag that decides whether the flag takes part in arbitration. Each source also has a control register, tied to it in hardware. The register holds a 3-bit urgency level and a service-type bit.

On every clock the arbiter picks the enabled pending source with the numerically smallest level. When levels are equal, the lower source number wins. Level 7 marks a source as switched off. The winner's level, number and service-type bit are registered and driven out. An acceptance output reports whether the CPU takes the request. It is high only at an instruction-boundary strobe, and only when the level is strictly below the CPU's current level mask and the CPU's global interrupt-enable bit is set.

Software clears request flags through a write-one-to-clear vector. It loads the enable mask as a whole word. It programs one control register per write.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pulse on `evt_i[k]` sets request flag k at the next clock edge. The flag then stays set until it is cleared, and it is visible on `pend_o[k]`.
- R2: A 1 on `clr_i[k]` clears flag k at the next edge. If `evt_i[k]` is also 1 in that cycle, the flag stays set.
- R3: Only sources with both the request flag and the enable flag set take part in arbitration. `en_wr_i` loads the whole enable mask from `en_data_i`. The mask resets to all zeros.
- R4: Among the sources that take part, the one with the numerically smallest level wins.
- R5: Among sources that share the winning level, the one with the lowest source number wins.
- R6: A source with level 7 never wins. After reset every level is 7 and every service-type bit is 0.
- R7: The result is registered. A flag set at edge k shows on `irq_valid_o`, `irq_level_o`, `irq_id_o` and `irq_svc_o` after edge k+1. If flags, enables and configuration do not change, the result does not change.
- R8: `accept_o` is 1 only in a cycle where `boundary_i`=1, `irq_valid_o`=1, `irq_level_o` < `cpu_ilm_i` (strictly less) and `cpu_ien_i`=1. It responds to these signals without an added register.
- R9: `cfg_wr_i` writes `cfg_level_i` and `cfg_svc_i` into the control register of source `cfg_idx_i`. The winner's service-type bit is driven on `irq_svc_o`, where 0 means normal interrupt handling.
- R10: While `rst_ni` is low, all flags are cleared, `irq_valid_o`, `irq_level_o`, `irq_id_o`, `irq_svc_o` and `accept_o` are 0, and `pend_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_SRC | Per-source event pulses that set the request flags |
| clr_i | input | NUM_SRC | Write-one-to-clear for the request flags |
| en_wr_i | input | 1 | Load strobe for the enable mask |
| en_data_i | input | NUM_SRC | New enable mask |
| cfg_wr_i | input | 1 | Write strobe for a control register |
| cfg_idx_i | input | IDX_W | Source number of the control register being written |
| cfg_level_i | input | 3 | Level to write |
| cfg_svc_i | input | 1 | Service-type bit to write |
| cpu_ilm_i | input | 3 | CPU level mask |
| cpu_ien_i | input | 1 | CPU global interrupt enable |
| boundary_i | input | 1 | Instruction-boundary strobe |
| pend_o | output | NUM_SRC | Current request flags |
| irq_valid_o | output | 1 | A winner is being presented |
| irq_level_o | output | 3 | Level of the winner |
| irq_id_o | output | IDX_W | Source number of the winner |
| irq_svc_o | output | 1 | Service-type bit of the winner |
| accept_o | output | 1 | The CPU takes the presented request |

## Verification
The bench targets the tie between equal levels. A comparison that allows equality would hand the request to the higher-numbered source. It also targets a source left at level 7: an arbiter seeded with the wrong sentinel would present it as valid.

A clear that lands in the same cycle as a new event must leave the flag set. A design that gives the clear priority would lose that event.

Acceptance is probed with the level equal to the mask, with the enable bit low, and with the strobe absent. Each probe catches a comparison or a gate that is too loose. Latency is sampled one cycle early as well as on time, which exposes a missing or an extra pipeline register.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_OFF = '1;

  typedef struct packed {
    lvl_t level;
    logic svc;
  } src_cfg_t;

  localparam src_cfg_t CFG_RST = '{level: LVL_OFF, svc: 1'b0};
endpackage

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_data_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic [NUM_SRC-1:0] active_o
);
  logic [NUM_SRC-1:0] req_q, en_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          req_q[g] <= 1'b0;
      else if (evt_i[g])    req_q[g] <= 1'b1;  // event beats clear
      else if (clr_i[g])    req_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_wr_i) en_q <= en_data_i;
  end

  assign req_o    = req_q;
  assign active_o = req_q & en_q;

  assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((req_q & $past(evt_i)) == $past(evt_i)));
  assert_clr_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~evt_i) != '0) |=> ((req_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  lvl_t                       level_i,
  input  logic                       svc_i,
  output src_cfg_t [NUM_SRC-1:0]     cfg_o
);
  src_cfg_t [NUM_SRC-1:0] cfg_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[g] <= CFG_RST;
      else if (wr_i && (idx_i == IDX_W'(g)))
        cfg_q[g] <= '{level: level_i, svc: svc_i};
    end
  end

  assign cfg_o = cfg_q;

  assert_cfg_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (32'(idx_i) < NUM_SRC)) |=>
      (cfg_q[$past(idx_i)].level == $past(level_i)) && (cfg_q[$past(idx_i)].svc == $past(svc_i)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_SRC-1:0]     active_i,
  input  src_cfg_t [NUM_SRC-1:0] cfg_i,
  output logic                   valid_o,
  output lvl_t                   level_o,
  output logic [IDX_W-1:0]       id_o,
  output logic                   svc_o
);
  lvl_t             best_lvl;
  logic [IDX_W-1:0] best_id;
  logic             best_svc;

  // Strict compare keeps the lower index on ties; seed at LVL_OFF drops level 7.
  always_comb begin
    best_lvl = LVL_OFF;
    best_id  = '0;
    best_svc = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active_i[i] && (cfg_i[i].level < best_lvl)) begin
        best_lvl = cfg_i[i].level;
        best_id  = IDX_W'(i);
        best_svc = cfg_i[i].svc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      level_o <= '0;
      id_o    <= '0;
      svc_o   <= 1'b0;
    end else begin
      valid_o <= (best_lvl != LVL_OFF);
      level_o <= (best_lvl != LVL_OFF) ? best_lvl : '0;
      id_o    <= best_id;
      svc_o   <= best_svc;
    end
  end

  assert_no_off_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (level_o != LVL_OFF));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(active_i) && $stable(cfg_i)) |=> ($stable(valid_o) && $stable(level_o) && $stable(id_o)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_data_i,
  input  logic               cfg_wr_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [2:0]         cfg_level_i,
  input  logic               cfg_svc_i,
  input  logic [2:0]         cpu_ilm_i,
  input  logic               cpu_ien_i,
  input  logic               boundary_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_valid_o,
  output logic [2:0]         irq_level_o,
  output logic [IDX_W-1:0]   irq_id_o,
  output logic               irq_svc_o,
  output logic               accept_o
);
  logic [NUM_SRC-1:0]     active;
  src_cfg_t [NUM_SRC-1:0] cfg;

  irq_src_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i, .rst_ni, .evt_i, .clr_i, .en_wr_i, .en_data_i,
    .req_o(pend_o), .active_o(active)
  );

  irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i), .idx_i(cfg_idx_i),
    .level_i(cfg_level_i), .svc_i(cfg_svc_i), .cfg_o(cfg)
  );

  irq_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk_i, .rst_ni, .active_i(active), .cfg_i(cfg),
    .valid_o(irq_valid_o), .level_o(irq_level_o), .id_o(irq_id_o), .svc_o(irq_svc_o)
  );

  assign accept_o = boundary_i & irq_valid_o & cpu_ien_i & (irq_level_o < cpu_ilm_i);

  assert_accept_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (irq_valid_o && (irq_level_o != LVL_OFF)));
  assert_reset_quiet_R10: assert final (rst_ni || (!irq_valid_o && !accept_o));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] evt_i = '0, clr_i = '0, en_data_i = '0;
  logic en_wr_i = 1'b0, cfg_wr_i = 1'b0, cfg_svc_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic [2:0] cfg_level_i = '0, cpu_ilm_i = '0;
  logic cpu_ien_i = 1'b0, boundary_i = 1'b0;
  logic [N-1:0] pend_o;
  logic irq_valid_o, irq_svc_o, accept_o;
  logic [2:0] irq_level_o;
  logic [IW-1:0] irq_id_o;

  int checks = 0, errors = 0;

  irq_prio_ctrl #(.NUM_SRC(N)) dut_i (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic cfg(int idx, int lvl, bit svc);
    cfg_wr_i = 1; cfg_idx_i = IW'(idx); cfg_level_i = 3'(lvl); cfg_svc_i = svc;
    step(); cfg_wr_i = 0;
  endtask

  task automatic set_en(logic [N-1:0] m);
    en_wr_i = 1; en_data_i = m; step(); en_wr_i = 0;
  endtask

  task automatic fire(logic [N-1:0] m);
    evt_i = m; step(); evt_i = '0;
  endtask

  task automatic clean();
    clr_i = '1; step(); clr_i = '0;
    set_en('0);
    for (int i = 0; i < N; i++) cfg(i, 7, 0);
    step();
  endtask

  task automatic t_reset();
    chk("R10 valid", irq_valid_o, 0);
    chk("R10 pend", int'(pend_o), 0);
    chk("R10 accept", accept_o, 0);
    chk("R10 level", irq_level_o, 0);
  endtask

  task automatic t_basic();
    cfg(3, 2, 0);
    set_en(16'h0008);
    fire(16'h0008);
    chk("R1 pend set", int'(pend_o[3]), 1);
    chk("R7 not yet valid", irq_valid_o, 0);
    step();
    chk("R7 valid", irq_valid_o, 1);
    chk("R4 id", irq_id_o, 3);
    chk("R4 level", irq_level_o, 2);
    chk("R9 svc", irq_svc_o, 0);
    step(); step();
    chk("R1 flag held", int'(pend_o[3]), 1);
    chk("R7 held id", irq_id_o, 3);
  endtask

  task automatic t_disabled();
    cfg(5, 0, 0);
    fire(16'h0020);
    step();
    chk("R3 pend w/o enable", int'(pend_o[5]), 1);
    chk("R3 disabled ignored", irq_id_o, 3);
  endtask

  task automatic t_lower_level();
    cfg(10, 1, 1);
    set_en(16'h0408);
    fire(16'h0400);
    step();
    chk("R4 smaller level wins", irq_id_o, 10);
    chk("R4 level", irq_level_o, 1);
    chk("R9 svc of winner", irq_svc_o, 1);
  endtask

  task automatic t_tie();
    cfg(1, 1, 0);
    set_en(16'h040A);
    fire(16'h0002);
    step();
    chk("R5 tie lower id", irq_id_o, 1);
    cfg(12, 1, 0);
    set_en(16'h140A);
    fire(16'h1000);
    step();
    chk("R5 tie keeps lower id", irq_id_o, 1);
  endtask

  task automatic t_off_level();
    clean();
    chk("R6 reset-level idle", irq_valid_o, 0);
    set_en(16'h0010);
    fire(16'h0010);
    step();
    chk("R6 level7 pend", int'(pend_o[4]), 1);
    chk("R6 level7 never wins", irq_valid_o, 0);
    cfg(4, 6, 0);
    step();
    chk("R6 level6 wins", irq_valid_o, 1);
    chk("R6 level6 value", irq_level_o, 6);
  endtask

  task automatic t_clear();
    clr_i = 16'h0010; evt_i = 16'h0010; step(); clr_i = '0; evt_i = '0;
    chk("R2 event beats clear", int'(pend_o[4]), 1);
    clr_i = 16'h0010; step(); clr_i = '0;
    chk("R2 clear", int'(pend_o[4]), 0);
    step();
    chk("R2 winner gone", irq_valid_o, 0);
  endtask

  task automatic t_accept();
    clean();
    cfg(6, 3, 0);
    set_en(16'h0040);
    fire(16'h0040);
    step();
    cpu_ilm_i = 3'd4; cpu_ien_i = 1; boundary_i = 0; #1;
    chk("R8 no boundary", accept_o, 0);
    boundary_i = 1; #1;
    chk("R8 accept", accept_o, 1);
    cpu_ilm_i = 3'd3; #1;
    chk("R8 equal level rejected", accept_o, 0);
    cpu_ilm_i = 3'd7; cpu_ien_i = 0; #1;
    chk("R8 ien low", accept_o, 0);
    boundary_i = 0; cpu_ien_i = 0; cpu_ilm_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_basic();
    t_disabled();
    t_lower_level();
    t_tie();
    t_off_level();
    t_clear();
    t_accept();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule